// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache

This block caches virtual-to-physical page translations for a 64-bit paged memory system. It has 64 slots, and each slot is either empty or holds one translation. A translation carries the following:
- an address-space identifier and a global flag;
- the page-table entry and the address that entry was read from;
- a low-bit mask derived from the page-table level, so that large pages (superpages) cover more address space with one entry;
- a stamp taken from a free-running cycle counter at the moment the entry was written.

Every operation picks its slot from the six lowest virtual page number bits, which are virtual address bits [17:12]. A lookup reads only that one slot, and its result appears registered on the next clock. A fill places a new translation into the slot of the faulting address. For a superpage this means one superpage can end up held in several slots. Each copy appears when a different page of that superpage misses and is filled.

An indexed write replaces a chosen slot outright. A flush invalidates every slot that passes a filter made of an optional address-space identifier and an optional address. A clear empties the whole table. A page walker is expected to drive the fill port on a miss, and fence logic is expected to drive the flush port.

Top module: `dmtlb`

## Requirements
- R1: After reset, and on the cycle after `clr` is high, every slot is empty, so every lookup misses. `clr` takes priority over flush and over any write in the same cycle.
- R2: The slot used by a lookup and by a fill is virtual address bits [17:12]. On a hit, `lk_index` reports that slot.
- R3: A lookup hits when the slot is valid, the entry is global or its identifier equals `lk_asid`, and `lk_vaddr` with its low masked bits cleared equals the stored virtual base.
- R4: The low mask of an entry covers the bottom 12 + 9 × level bits. The level is 0, 1, 2 or 3. The virtual and physical bases are stored with those bits cleared. A hit returns the physical base ORed with the masked-off low bits of `lk_vaddr`, together with the stored PTE, PTE address and global flag.
- R5: A superpage fill writes only the slot of its own address. A page of the same superpage whose bits [17:12] differ still misses. A page whose bits [17:12] are equal hits through that entry.
- R6: `wr_en` writes the whole entry into slot `wr_index`, whatever bits [17:12] of `in_vaddr` are, and marks the slot valid. When `wr_en` is high, `fill_en` in the same cycle is ignored.
- R7: A flush removes valid entries by filter. With no filter, every entry is removed. With an address filter only, an entry is removed when the flush address with the entry's low bits cleared matches its base. With an identifier filter only, non-global entries carrying that identifier are removed. With both filters, both conditions must hold, and global entries stay.
- R8: When `fsh_en` is high, any fill or indexed write in the same cycle is dropped. A flush never makes a slot valid.
- R9: The lookup result is registered. The outputs reflect the table as it was before the edge that samples the request. When `lk_valid` is low, `lk_hit` is low on the next cycle.
- R10: `lk_age` returns the cycle counter value at the edge that wrote the entry. The counter is 0 during reset and advances by one at every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empty every slot |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_vaddr | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Registered hit |
| lk_index | output | 6 | Registered slot of the lookup |
| lk_paddr | output | 64 | Translated physical address |
| lk_pte | output | 64 | Stored page-table entry |
| lk_pte_addr | output | 64 | Stored PTE address |
| lk_global | output | 1 | Stored global flag |
| lk_age | output | 64 | Stored age stamp |
| fill_en | input | 1 | Install at slot of `in_vaddr` |
| wr_en | input | 1 | Install at slot `wr_index` |
| wr_index | input | 6 | Slot for indexed write |
| in_asid | input | 16 | Identifier of installed entry |
| in_global | input | 1 | Global flag of installed entry |
| in_level | input | 2 | Page-table level of installed entry |
| in_vaddr | input | 64 | Virtual address of installed entry |
| in_paddr | input | 64 | Physical address of installed entry |
| in_pte | input | 64 | Page-table entry value |
| in_pte_addr | input | 64 | Address the PTE was read from |
| fsh_en | input | 1 | Flush request |
| fsh_use_asid | input | 1 | Apply identifier filter |
| fsh_asid | input | 16 | Flush identifier |
| fsh_use_addr | input | 1 | Apply address filter |
| fsh_vaddr | input | 64 | Flush address |

## Verification
Some rules are checked on every cycle, whatever the traffic:
- the table is empty after a clear;
- no flush-selected slot survives a flush;
- a flush never raises the number of valid slots;
- every accepted install leaves its target slot valid;
- an idle lookup yields no hit;
- a hit always reports the slot named by bits [17:12] of the request.

Some behaviour only the bench scenarios can show. This covers the translated address, and superpage copies that hit or miss depending on the page's bits [17:12]. It covers each of the four flush filter modes, with global entries surviving identifier flushes. It also covers the age stamp, and fills lost to a flush or clear in the same cycle. The bench compares all of these against its own model of the table, under directed cases and random traffic.

// File: rtl/dmtlb_pkg.sv
package dmtlb_pkg;
  parameter int XLEN      = 64;
  parameter int ASID_W    = 16;
  parameter int PTE_W     = 64;
  parameter int AGE_W     = 64;
  parameter int LVL_W     = 2;
  parameter int PAGE_BITS = 12;
  parameter int LVL_BITS  = 9;
  parameter int ENTRIES   = 64;
  localparam int IDX_W    = $clog2(ENTRIES);

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic              glb;
    logic [PTE_W-1:0]  pte;
    logic [XLEN-1:0]   pte_addr;
    logic [XLEN-1:0]   lo_mask;
    logic [XLEN-1:0]   vbase;
    logic [XLEN-1:0]   pbase;
    logic [AGE_W-1:0]  age;
  } tlb_entry_t;

  // Ones in the offset bits covered by a page of the given level.
  function automatic logic [XLEN-1:0] level_mask(input logic [LVL_W-1:0] lvl);
    int sh;
    sh = PAGE_BITS + int'(lvl) * LVL_BITS;
    if (sh >= XLEN) return '1;
    return (XLEN'(1) << sh) - XLEN'(1);
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [XLEN-1:0] va);
    return va[PAGE_BITS +: IDX_W];
  endfunction

  function automatic logic entry_hit(input tlb_entry_t e, input logic [ASID_W-1:0] asid,
                                     input logic [XLEN-1:0] va);
    return (e.glb || (e.asid == asid)) && ((va & ~e.lo_mask) == e.vbase);
  endfunction

  function automatic logic flush_hit(input tlb_entry_t e, input logic use_asid,
                                     input logic [ASID_W-1:0] asid, input logic use_addr,
                                     input logic [XLEN-1:0] va);
    logic a_ok, v_ok;
    a_ok = !use_asid || (!e.glb && (e.asid == asid));
    v_ok = !use_addr || ((va & ~e.lo_mask) == e.vbase);
    return a_ok && v_ok;
  endfunction

  function automatic logic [XLEN-1:0] translate(input tlb_entry_t e, input logic [XLEN-1:0] va);
    return e.pbase | (va & e.lo_mask);
  endfunction
endpackage

// File: rtl/dmtlb_age_ctr.sv
module dmtlb_age_ctr #(
  parameter int AGE_W = dmtlb_pkg::AGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [AGE_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + AGE_W'(1);
  end
endmodule

// File: rtl/dmtlb_flush_sel.sv
module dmtlb_flush_sel
  import dmtlb_pkg::*;
#(
  parameter int N = ENTRIES
) (
  input  tlb_entry_t [N-1:0] ents,
  input  logic [N-1:0]       valid,
  input  logic               fsh_en,
  input  logic               use_asid,
  input  logic [ASID_W-1:0]  asid,
  input  logic               use_addr,
  input  logic [XLEN-1:0]    vaddr,
  output logic [N-1:0]       kill
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    assign kill[i] = fsh_en && valid[i] && flush_hit(ents[i], use_asid, asid, use_addr, vaddr);
  end
endmodule

// File: rtl/dmtlb_store.sv
module dmtlb_store
  import dmtlb_pkg::*;
#(
  parameter int N = ENTRIES,
  localparam int IW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               fsh_en,
  input  logic [N-1:0]       kill,
  input  logic               wr_fire,
  input  logic [IW-1:0]      wr_idx,
  input  tlb_entry_t         wr_ent,
  input  logic [IW-1:0]      rd_idx,
  output tlb_entry_t         rd_ent,
  output logic               rd_valid,
  output tlb_entry_t [N-1:0] ents,
  output logic [N-1:0]       valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid <= '0;
    else if (clr)     valid <= '0;
    else if (fsh_en)  valid <= valid & ~kill;
    else if (wr_fire) valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_fire) ents[wr_idx] <= wr_ent;
  end

  assign rd_ent   = ents[rd_idx];
  assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/dmtlb_lookup.sv
module dmtlb_lookup
  import dmtlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [XLEN-1:0]   lk_vaddr,
  input  tlb_entry_t        slot_ent,
  input  logic              slot_valid,
  output logic              match,
  output logic              hit_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [XLEN-1:0]   paddr_q,
  output logic [PTE_W-1:0]  pte_q,
  output logic [XLEN-1:0]   pte_addr_q,
  output logic              glb_q,
  output logic [AGE_W-1:0]  age_q
);
  assign match = lk_valid && slot_valid && entry_hit(slot_ent, lk_asid, lk_vaddr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0; idx_q <= '0; paddr_q <= '0; pte_q <= '0;
      pte_addr_q <= '0; glb_q <= 1'b0; age_q <= '0;
    end else begin
      hit_q      <= match;
      idx_q      <= slot_of(lk_vaddr);
      paddr_q    <= translate(slot_ent, lk_vaddr);
      pte_q      <= slot_ent.pte;
      pte_addr_q <= slot_ent.pte_addr;
      glb_q      <= slot_ent.glb;
      age_q      <= slot_ent.age;
    end
  end
endmodule

// File: rtl/dmtlb.sv
module dmtlb
  import dmtlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [XLEN-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_index,
  output logic [XLEN-1:0]   lk_paddr,
  output logic [PTE_W-1:0]  lk_pte,
  output logic [XLEN-1:0]   lk_pte_addr,
  output logic              lk_global,
  output logic [AGE_W-1:0]  lk_age,
  input  logic              fill_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [ASID_W-1:0] in_asid,
  input  logic              in_global,
  input  logic [LVL_W-1:0]  in_level,
  input  logic [XLEN-1:0]   in_vaddr,
  input  logic [XLEN-1:0]   in_paddr,
  input  logic [PTE_W-1:0]  in_pte,
  input  logic [XLEN-1:0]   in_pte_addr,
  input  logic              fsh_en,
  input  logic              fsh_use_asid,
  input  logic [ASID_W-1:0] fsh_asid,
  input  logic              fsh_use_addr,
  input  logic [XLEN-1:0]   fsh_vaddr
);
  // Named internal events, observed by the bound checker.
  logic                    install_fire;
  logic [IDX_W-1:0]        install_idx;
  logic [ENTRIES-1:0]      kill_vec;
  logic [ENTRIES-1:0]      valid_vec;
  logic                    lookup_match;

  logic [AGE_W-1:0]        age_now;
  tlb_entry_t              new_ent, rd_ent;
  tlb_entry_t [ENTRIES-1:0] all_ents;
  logic                    rd_valid;
  logic [XLEN-1:0]         new_mask;

  assign install_fire = (fill_en || wr_en) && !fsh_en && !clr;
  assign install_idx  = wr_en ? wr_index : slot_of(in_vaddr);
  assign new_mask     = level_mask(in_level);

  always_comb begin
    new_ent          = '0;
    new_ent.asid     = in_asid;
    new_ent.glb      = in_global;
    new_ent.pte      = in_pte;
    new_ent.pte_addr = in_pte_addr;
    new_ent.lo_mask  = new_mask;
    new_ent.vbase    = in_vaddr & ~new_mask;
    new_ent.pbase    = in_paddr & ~new_mask;
    new_ent.age      = age_now;
  end

  dmtlb_age_ctr #(.AGE_W(AGE_W)) i_age (.clk(clk), .rst_n(rst_n), .count(age_now));

  dmtlb_flush_sel #(.N(ENTRIES)) i_fsel (
    .ents(all_ents), .valid(valid_vec), .fsh_en(fsh_en), .use_asid(fsh_use_asid),
    .asid(fsh_asid), .use_addr(fsh_use_addr), .vaddr(fsh_vaddr), .kill(kill_vec));

  dmtlb_store #(.N(ENTRIES)) i_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fsh_en(fsh_en), .kill(kill_vec),
    .wr_fire(install_fire), .wr_idx(install_idx), .wr_ent(new_ent),
    .rd_idx(slot_of(lk_vaddr)), .rd_ent(rd_ent), .rd_valid(rd_valid),
    .ents(all_ents), .valid(valid_vec));

  dmtlb_lookup i_look (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
    .slot_ent(rd_ent), .slot_valid(rd_valid), .match(lookup_match),
    .hit_q(lk_hit), .idx_q(lk_index), .paddr_q(lk_paddr), .pte_q(lk_pte),
    .pte_addr_q(lk_pte_addr), .glb_q(lk_global), .age_q(lk_age));
endmodule

// File: rtl/dmtlb_chk.sv
module dmtlb_chk
  import dmtlb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               lk_valid,
  input logic [XLEN-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic [IDX_W-1:0]   lk_index,
  input logic               fsh_en,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] kill_vec,
  input logic               install_fire,
  input logic [IDX_W-1:0]   install_idx
);
  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_vec == '0));

  assert_hit_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!lk_hit || (lk_index == $past(lk_vaddr[PAGE_BITS +: IDX_W]))));

  assert_install_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    install_fire |=> valid_vec[$past(install_idx)]);

  assert_flush_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsh_en && !clr) |=> ((valid_vec & $past(kill_vec)) == '0));

  assert_flush_no_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fsh_en |=> ($countones(valid_vec) <= $countones($past(valid_vec))));

  assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit);
endmodule

bind dmtlb dmtlb_chk i_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_index(lk_index), .fsh_en(fsh_en), .valid_vec(valid_vec),
  .kill_vec(kill_vec), .install_fire(install_fire), .install_idx(install_idx));

// File: tb/test_dmtlb.sv
module test_dmtlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        clr, lk_valid, fill_en, wr_en, in_global, fsh_en, fsh_use_asid, fsh_use_addr;
  logic [15:0] lk_asid, in_asid, fsh_asid;
  logic [63:0] lk_vaddr, in_vaddr, in_paddr, in_pte, in_pte_addr, fsh_vaddr;
  logic [5:0]  wr_index;
  logic [1:0]  in_level;
  logic        lk_hit, lk_global;
  logic [5:0]  lk_index;
  logic [63:0] lk_paddr, lk_pte, lk_pte_addr, lk_age;

  dmtlb i_dmtlb (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  longint unsigned cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Bench model of the table.
  bit          m_v [64];
  logic [63:0] m_vb[64], m_pb[64], m_msk[64], m_pte[64], m_pa[64], m_age[64];
  logic [15:0] m_as[64];
  bit          m_g [64];

  function automatic logic [63:0] lvl_bits(input int lvl);
    int n = 12 + 9 * lvl;
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = 1'b1;
    return r;
  endfunction

  task automatic idle();
    clr = 0; lk_valid = 0; fill_en = 0; wr_en = 0; fsh_en = 0;
    fsh_use_asid = 0; fsh_use_addr = 0; in_global = 0; lk_asid = 0; in_asid = 0;
    fsh_asid = 0; lk_vaddr = 0; in_vaddr = 0; in_paddr = 0; in_pte = 0; in_pte_addr = 0;
    fsh_vaddr = 0; wr_index = 0; in_level = 0;
  endtask

  task automatic look(input logic [15:0] a, input logic [63:0] va);
    lk_valid = 1; lk_asid = a; lk_vaddr = va;
  endtask

  task automatic put(input bit g, input logic [15:0] a, input int lvl,
                     input logic [63:0] va, input logic [63:0] pa);
    in_global = g; in_asid = a; in_level = 2'(lvl); in_vaddr = va; in_paddr = pa;
    in_pte = {va[31:0], pa[31:0]} ^ 64'h5a5a; in_pte_addr = pa ^ 64'h1_0000_0000;
  endtask

  task automatic flush(input bit ua, input logic [15:0] a, input bit uv, input logic [63:0] va);
    fsh_en = 1; fsh_use_asid = ua; fsh_asid = a; fsh_use_addr = uv; fsh_vaddr = va;
  endtask

  // One clock: predict, update model, sample at the next falling edge.
  task automatic tick(input string tag);
    int i; bit eh; logic [63:0] ep, ept, epa, eag; bit eg; logic [63:0] m;
    i = int'(lk_vaddr[17:12]);
    eh = lk_valid && m_v[i] && (m_g[i] || m_as[i] == lk_asid) && ((lk_vaddr & ~m_msk[i]) == m_vb[i]);
    ep = m_pb[i] | (lk_vaddr & m_msk[i]); ept = m_pte[i]; epa = m_pa[i]; eg = m_g[i]; eag = m_age[i];
    if (clr) begin
      for (int k = 0; k < 64; k++) m_v[k] = 0;
    end else if (fsh_en) begin
      for (int k = 0; k < 64; k++)
        if (m_v[k] && (!fsh_use_asid || (!m_g[k] && m_as[k] == fsh_asid)) &&
            (!fsh_use_addr || ((fsh_vaddr & ~m_msk[k]) == m_vb[k]))) m_v[k] = 0;
    end else if (fill_en || wr_en) begin
      int j = wr_en ? int'(wr_index) : int'(in_vaddr[17:12]);
      m = lvl_bits(int'(in_level));
      m_v[j] = 1; m_vb[j] = in_vaddr & ~m; m_pb[j] = in_paddr & ~m; m_msk[j] = m;
      m_as[j] = in_asid; m_g[j] = in_global; m_pte[j] = in_pte; m_pa[j] = in_pte_addr;
      m_age[j] = 64'(cyc);
    end
    @(negedge clk);
    checks++;
    if (lk_hit !== eh || (eh && (lk_index !== 6'(i) || lk_paddr !== ep || lk_pte !== ept ||
        lk_pte_addr !== epa || lk_global !== eg || lk_age !== eag))) begin
      errors++;
      $display("FAIL %s: hit=%0b idx=%0d pa=%h age=%0d expected hit=%0b idx=%0d pa=%h age=%0d",
               tag, lk_hit, lk_index, lk_paddr, lk_age, eh, i, ep, eag);
    end
    idle();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] b;
    void'($urandom(32'd20241));
    for (int k = 0; k < 64; k++) m_v[k] = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    look(1, 64'h40_0000_3000); tick("R1");
    look(1, 64'h40_0000_3000); tick("R1");
    // R3/R4/R10: basic page
    put(0, 1, 0, 64'h40_0000_3000, 64'h8_0012_3000); fill_en = 1; tick("R10");
    look(1, 64'h40_0000_30ab); tick("R4");
    look(2, 64'h40_0000_30ab); tick("R3");
    look(1, 64'h41_0000_3000); tick("R3");
    // R9: idle lookup
    lk_vaddr = 64'h40_0000_3000; lk_asid = 1; tick("R9");
    // R3: global entry
    put(1, 2, 0, 64'h5000, 64'h7_7000); fill_en = 1; tick("R3");
    look(7, 64'h5123); tick("R3");
    // R5/R4: 2 MiB superpage
    b = 64'h4020_7000;
    put(0, 1, 1, b, 64'h9000_0000); fill_en = 1; tick("R5");
    look(1, b + 64'h345); tick("R4");
    look(1, 64'h4024_7000); tick("R5");
    look(1, 64'h4020_8000); tick("R5");
    // R6: indexed write copies superpage into slot 8
    put(0, 1, 1, b, 64'h9000_0000); wr_en = 1; wr_index = 6'd8; fill_en = 1; tick("R6");
    look(1, 64'h4020_8010); tick("R6");
    // R2: lookup in same cycle as fill sees old contents
    put(0, 1, 0, 64'h2_0000_c000, 64'h3_c000); fill_en = 1; look(1, 64'h2_0000_c000); tick("R9");
    look(1, 64'h2_0000_c000); tick("R2");
    // R7: address-only flush hits both superpage copies
    flush(0, 0, 1, 64'h4021_0000); tick("R7");
    look(1, b); tick("R7");
    look(1, 64'h4020_8000); tick("R7");
    look(1, 64'h40_0000_3000); tick("R7");
    // R7: identifier-only flush keeps global
    put(0, 2, 0, 64'h9000, 64'h1_9000); fill_en = 1; tick("R7");
    flush(1, 2, 0, 0); tick("R7");
    look(2, 64'h9000); tick("R7");
    look(2, 64'h5000); tick("R7");
    // R7: both filters
    put(0, 3, 0, 64'ha000, 64'h2_a000); fill_en = 1; tick("R7");
    flush(1, 3, 1, 64'hb000); tick("R7");
    look(3, 64'ha000); tick("R7");
    flush(1, 3, 1, 64'ha000); tick("R7");
    look(3, 64'ha000); tick("R7");
    // R8: flush beats fill
    put(0, 4, 0, 64'hd000, 64'h2_d000); fill_en = 1; flush(1, 16'h99, 0, 0); tick("R8");
    look(4, 64'hd000); tick("R8");
    // R7: unfiltered flush removes global too
    flush(0, 0, 0, 0); tick("R7");
    look(7, 64'h5000); tick("R7");
    // R1: clear beats fill
    put(0, 4, 0, 64'hd000, 64'h2_d000); fill_en = 1; tick("R1");
    put(0, 4, 0, 64'he000, 64'h2_e000); fill_en = 1; clr = 1; tick("R1");
    look(4, 64'hd000); tick("R1");
    look(4, 64'he000); tick("R1");
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom % 16;
      logic [63:0] va = (64'($urandom % 4) << 21) | (64'($urandom % 8) << 12) | 64'($urandom % 4096);
      if (op < 5) begin
        put($urandom % 4 == 0, 16'($urandom % 4), $urandom % 3, va, 64'($urandom) << 12);
        if (op == 0) begin wr_en = 1; wr_index = 6'($urandom % 8); end else fill_en = 1;
      end else if (op == 5) flush($urandom % 2, 16'($urandom % 4), $urandom % 2, va);
      else if (op == 6 && $urandom % 8 == 0) clr = 1;
      if ($urandom % 4 != 0)
        look(16'($urandom % 4), (64'($urandom % 4) << 21) | (64'($urandom % 8) << 12) | 64'($urandom % 4096));
      tick("R3");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule